// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block brings a two-bank EDO DRAM array out of power-up and then keeps it refreshed. After reset it waits out a power-up pause. It then issues a burst of CAS-before-RAS refresh cycles that primes the array's internal refresh counter, and raises `init_done` once that burst completes. From then on a free-running interval timer marks each point at which one more row refresh is owed. Because the DRAM supplies the refresh row address from its own counter, the block generates no address.

The DRAM strobes are shared with an access controller. When refresh work is owed, the block raises `ref_req` and keeps every strobe inactive until `ref_gnt` comes back. With the grant held it first spends one cycle with all strobes high (ARM), which gives CAS precharge and WE setup before RAS. Each refresh then runs three timed phases: CAS low with RAS high (CAS_LEAD), both low (RAS_LOW), and both high (PRECHARGE). All four RAS lines move together, so both banks are refreshed at once, and all four CAS lines move together. WE stays high. Refreshes that fall due while the pins are busy are counted as debt, which saturates at `MAX_DEBT`. The debt is paid back-to-back under a single grant. The request is released only after the last precharge has completed.

States: PAUSE (power-up wait) goes to IDLE when the pause ends. IDLE goes to REQ when work is owed. REQ goes to ARM when the grant is seen. ARM goes to CAS_LEAD after one cycle. CAS_LEAD goes to RAS_LOW after `CSR_CYC` cycles. RAS_LOW goes to PRECHARGE after `RAS_CYC` cycles. After `RP_CYC` cycles, PRECHARGE goes back to CAS_LEAD if work is still owed, and otherwise to IDLE.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and afterwards, until at least `PAUSE_CYC` clock cycles have passed, all `ras_n` and `cas_n` bits are 1 (inactive), `we_n` is 1, `ref_req` is 0 and `init_done` is 0. The first request appears no later than `PAUSE_CYC`+2 cycles after reset release.
- R2: No `ras_n` or `cas_n` bit is driven low unless `ref_req` is high and `ref_gnt` is high.
- R3: Each refresh is CAS-before-RAS. CAS falls while RAS is high, after at least one cycle in which the grant was already present with all strobes high. RAS falls exactly `CSR_CYC` cycles after CAS. `we_n` stays 1 at all times.
- R4: RAS stays low for exactly `RAS_CYC` cycles with CAS low throughout. RAS and CAS rise together. RAS then stays high for at least `RP_CYC` cycles before it can fall again.
- R5: The four `ras_n` bits always carry equal values, and so do the four `cas_n` bits.
- R6: `init_done` rises in the same cycle as the RAS rise that ends the `INIT_CBR`-th refresh after the pause. These initial refreshes run back-to-back under one request. Once high, `init_done` stays high until reset.
- R7: After the pause, one refresh falls due every `REF_INTERVAL_CYC` cycles. With the grant given at once, successive requests start exactly `REF_INTERVAL_CYC` cycles apart. Refreshes owed while the grant is withheld are all performed back-to-back under the next grant.
- R8: Owed refreshes saturate at `MAX_DEBT`. A refresh that falls due while `MAX_DEBT` are already owed is dropped, so a withheld grant yields a burst of at most `MAX_DEBT` refreshes.
- R9: `ref_req` falls exactly `RP_CYC` cycles after the last RAS rise of a burst, with all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | output | 1 | Request for the shared DRAM pins |
| ref_gnt | input | 1 | Pins granted to this block |
| ras_n | output | NUM_RAS | Row strobes, active low, all bits equal |
| cas_n | output | NUM_CAS | Column strobes, active low, all bits equal |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Array initialised and usable |

## Verification
The grant is first given immediately, which isolates the periodic schedule and the phase lengths of a single refresh. The grant delay is then swept over several cycle counts to show that the strobes wait for the grant whatever its latency. Next, the grant is withheld for one to six whole refresh intervals, with the release point placed between two due times. The expected burst length min(k, MAX_DEBT) separates correct debt accumulation from lost debt (burst of one) and from missing saturation (burst above the cap). The power-up burst shows the pause length, the initial refresh count and the point at which `init_done` rises.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_ARM,
        ST_CAS,
        ST_RAS,
        ST_PRE
    } ref_state_e;
endpackage

// File: rtl/ref_pause_tick.sv
module ref_pause_tick #(
    parameter int PAUSE_CYC    = 10000,
    parameter int INTERVAL_CYC = 750
) (
    input  logic clk,
    input  logic rst_n,
    output logic pause_done,
    output logic tick
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam logic [PW-1:0] PAUSE_END = PW'(PAUSE_CYC);
    localparam logic [TW-1:0] TICK_END  = TW'(INTERVAL_CYC - 1);

    logic [PW-1:0] pause_q;
    logic [TW-1:0] iv_q;

    assign pause_done = (pause_q == PAUSE_END);
    assign tick       = pause_done && (iv_q == TICK_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_q <= '0;
            iv_q    <= '0;
        end else if (!pause_done) begin
            pause_q <= pause_q + 1'b1;
        end else if (tick) begin
            iv_q <= '0;
        end else begin
            iv_q <= iv_q + 1'b1;
        end
    end
endmodule

// File: rtl/ref_work_ctr.sv
module ref_work_ctr #(
    parameter int INIT_CBR = 8,
    parameter int MAX_DEBT = 8,
    parameter int DEBT_W   = $clog2(MAX_DEBT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cyc_done,
    output logic              pending,
    output logic              init_done,
    output logic [DEBT_W-1:0] debt
);
    localparam int NW = $clog2(INIT_CBR + 1);
    localparam logic [NW-1:0]     INIT_LOAD = NW'(INIT_CBR);
    localparam logic [DEBT_W-1:0] DEBT_CAP  = DEBT_W'(MAX_DEBT);

    logic [NW-1:0]     init_q;
    logic [DEBT_W-1:0] debt_q;
    logic              inc, dec;

    assign inc       = tick && (debt_q != DEBT_CAP);
    assign dec       = cyc_done && (init_q == '0);
    assign init_done = (init_q == '0);
    assign pending   = (init_q != '0) || (debt_q != '0);
    assign debt      = debt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= INIT_LOAD;
            debt_q <= '0;
        end else begin
            if (cyc_done && init_q != '0)
                init_q <= init_q - 1'b1;
            if (inc && !dec)
                debt_q <= debt_q + 1'b1;
            else if (dec && !inc)
                debt_q <= debt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm
    import dram_ref_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int RP_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_done,
    input  logic pending,
    input  logic gnt,
    output logic req,
    output logic ras_on,
    output logic cas_on,
    output logic cyc_done
);
    localparam int PH_MAX = (CSR_CYC > RAS_CYC) ?
                            ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC) :
                            ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
    localparam int PHW = $clog2(PH_MAX + 1);
    localparam logic [PHW-1:0] CSR_LAST = PHW'(CSR_CYC - 1);
    localparam logic [PHW-1:0] RAS_LAST = PHW'(RAS_CYC - 1);
    localparam logic [PHW-1:0] RP_LAST  = PHW'(RP_CYC - 1);

    ref_state_e     state_q, state_d;
    logic [PHW-1:0] ph_q, ph_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSE: if (pause_done)       state_d = ST_IDLE;
            ST_IDLE:  if (pending)          state_d = ST_REQ;
            ST_REQ:   if (gnt)              state_d = ST_ARM;
            ST_ARM:                         state_d = ST_CAS;
            ST_CAS:   if (ph_q == CSR_LAST) state_d = ST_RAS;
            ST_RAS:   if (ph_q == RAS_LAST) state_d = ST_PRE;
            ST_PRE:   if (ph_q == RP_LAST)  state_d = pending ? ST_CAS : ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
        ph_d = (state_d != state_q) ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    always_comb begin
        req      = 1'b0;
        ras_on   = 1'b0;
        cas_on   = 1'b0;
        cyc_done = 1'b0;
        unique case (state_q)
            ST_PAUSE, ST_IDLE: ;
            ST_REQ, ST_ARM:    req = 1'b1;
            ST_CAS: begin
                req    = 1'b1;
                cas_on = 1'b1;
            end
            ST_RAS: begin
                req      = 1'b1;
                cas_on   = 1'b1;
                ras_on   = 1'b1;
                cyc_done = (ph_q == RAS_LAST);
            end
            ST_PRE:            req = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int NUM_RAS          = 4,
    parameter int NUM_CAS          = 4,
    parameter int PAUSE_CYC        = 10000,
    parameter int REF_INTERVAL_CYC = 750,
    parameter int INIT_CBR         = 8,
    parameter int MAX_DEBT         = 8,
    parameter int CSR_CYC          = 1,
    parameter int RAS_CYC          = 3,
    parameter int RP_CYC           = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               ref_req,
    input  logic               ref_gnt,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n,
    output logic               init_done
);
    localparam int DEBT_W = $clog2(MAX_DEBT + 1);

    logic              pause_done, tick, cyc_done, pending;
    logic              ras_on, cas_on;
    logic [DEBT_W-1:0] debt_w;

    ref_pause_tick #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INTERVAL_CYC (REF_INTERVAL_CYC)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_done (pause_done),
        .tick       (tick)
    );

    ref_work_ctr #(
        .INIT_CBR (INIT_CBR),
        .MAX_DEBT (MAX_DEBT),
        .DEBT_W   (DEBT_W)
    ) work_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cyc_done  (cyc_done),
        .pending   (pending),
        .init_done (init_done),
        .debt      (debt_w)
    );

    ref_strobe_fsm #(
        .CSR_CYC (CSR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_done (pause_done),
        .pending    (pending),
        .gnt        (ref_gnt),
        .req        (ref_req),
        .ras_on     (ras_on),
        .cas_on     (cas_on),
        .cyc_done   (cyc_done)
    );

    for (genvar gi = 0; gi < NUM_RAS; gi++) begin : g_ras
        assign ras_n[gi] = ~ras_on;
    end
    for (genvar gi = 0; gi < NUM_CAS; gi++) begin : g_cas
        assign cas_n[gi] = ~cas_on;
    end
    assign we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
    parameter int NUM_RAS  = 4,
    parameter int NUM_CAS  = 4,
    parameter int MAX_DEBT = 8,
    parameter int DEBT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_req,
    input logic               ref_gnt,
    input logic [NUM_RAS-1:0] ras_n,
    input logic [NUM_CAS-1:0] cas_n,
    input logic               init_done,
    input logic [DEBT_W-1:0]  debt
);
    AST_RAS_GANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == '0) || (ras_n == '1)); // R5
    AST_CAS_GANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1)); // R5
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n[0]) |-> (cas_n == '0) && ($past(cas_n) == '0)); // R3
    AST_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n[0] == 1'b0) |-> (cas_n == '0)); // R4
    AST_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ras_n != '1) || (cas_n != '1)) |-> (ref_req && ref_gnt)); // R2
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> (ras_n == '1) && (cas_n == '1) && ($past(ras_n) == '1)); // R9
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DEBT_W'(MAX_DEBT)); // R8
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .NUM_RAS  (NUM_RAS),
    .NUM_CAS  (NUM_CAS),
    .MAX_DEBT (MAX_DEBT),
    .DEBT_W   (DEBT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_req   (ref_req),
    .ref_gnt   (ref_gnt),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .init_done (init_done),
    .debt      (debt_w)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;
    localparam int PAUSE = 40;
    localparam int IVAL  = 60;
    localparam int NINIT = 8;
    localparam int MAXD  = 4;
    localparam int CSR   = 1;
    localparam int RASC  = 3;
    localparam int RP    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ref_req, we_n, init_done;
    logic [3:0] ras_n, cas_n;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC (PAUSE), .REF_INTERVAL_CYC (IVAL), .INIT_CBR (NINIT),
        .MAX_DEBT (MAXD), .CSR_CYC (CSR), .RAS_CYC (RASC), .RP_CYC (RP)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ref_req (ref_req), .ref_gnt (ref_gnt),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .init_done (init_done)
    );

    int tests = 0, fails = 0;
    bit finished = 0;
    bit gnt_en = 1;
    int j = 0, cf = 0, rf = 0, lr = 0, nref = 0, bref = 0, last_burst = 0;
    int first_req = -1, last_rise = 0, n_rise = 0, n_fall = 0, init_at = -1;
    bit have_lr = 0;
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e9 = 0;
    logic [3:0] p_ras = 4'hF, p_cas = 4'hF;
    logic p_req = 0, p_init = 0, p_gnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!(ras_n == 4'h0 || ras_n == 4'hF)) e5++;
            if (!(cas_n == 4'h0 || cas_n == 4'hF)) e5++;
            if (we_n !== 1'b1) e3++;
            if ((ras_n != 4'hF || cas_n != 4'hF) && !(ref_gnt && ref_req)) e2++;
            if (j < PAUSE && (ref_req || ras_n != 4'hF || cas_n != 4'hF || init_done)) e1++;
            if (p_cas == 4'hF && cas_n == 4'h0) begin
                if (p_ras != 4'hF || ras_n != 4'hF || !p_gnt) e3++;
                cf = j;
            end
            if (p_ras == 4'hF && ras_n == 4'h0) begin
                if (j - cf != CSR) e3++;
                if (have_lr && (j - lr < RP)) e4++;
                rf = j;
            end
            if (ras_n == 4'h0 && cas_n != 4'h0) e4++;
            if (p_ras == 4'h0 && ras_n == 4'hF) begin
                if (j - rf != RASC) e4++;
                if (cas_n != 4'hF) e4++;
                nref++; bref++; lr = j; have_lr = 1;
            end
            if (!p_req && ref_req) begin
                if (first_req < 0) first_req = j;
                last_rise = j; bref = 0; n_rise++;
            end
            if (p_req && !ref_req) begin
                if (j - lr != RP || ras_n != 4'hF || cas_n != 4'hF) e9++;
                last_burst = bref; n_fall++;
            end
            if (!p_init && init_done) init_at = nref;
            if (p_init && !init_done) e6++;
            p_ras = ras_n; p_cas = cas_n; p_req = ref_req; p_init = init_done;
            p_gnt = ref_gnt;
            ref_gnt = ref_req && gnt_en;
            j++;
        end
    end

    task automatic wait_rise();
        int o;
        o = n_rise;
        while (n_rise == o) @(posedge clk);
    endtask

    task automatic wait_fall();
        int o;
        o = n_fall;
        while (n_fall == o) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r0, r1, r2, exp;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        chk(ras_n == 4'hF && cas_n == 4'hF, "R1 strobes in reset", ras_n, 15);
        chk(we_n == 1'b1 && !ref_req && !init_done, "R1 req/init in reset",
            {ref_req, init_done}, 0);
        @(posedge clk); #5 rst_n = 1'b1;

        // R6: power-up burst
        wait_fall();
        chk(first_req >= PAUSE && first_req <= PAUSE + 2, "R1 first request cycle",
            first_req, PAUSE + 2);
        chk(init_done === 1'b1, "R6 init_done after burst", init_done, 1);
        chk(init_at == NINIT, "R6 refreshes before init_done", init_at, NINIT);
        chk(last_burst == NINIT, "R6 init burst back-to-back", last_burst, NINIT);

        // R7: periodic schedule with immediate grant
        wait_rise(); r0 = last_rise;
        wait_rise(); r1 = last_rise;
        wait_rise(); r2 = last_rise;
        chk(r1 - r0 == IVAL, "R7 interval 1", r1 - r0, IVAL);
        chk(r2 - r1 == IVAL, "R7 interval 2", r2 - r1, IVAL);
        wait_fall();
        chk(last_burst == 1, "R7 single refresh per interval", last_burst, 1);

        // R2: grant latency sweep
        for (int d = 0; d < 5; d++) begin
            gnt_en = 0;
            wait_rise();
            repeat (d) @(posedge clk);
            gnt_en = 1;
            wait_fall();
            chk(last_burst == 1, $sformatf("R2 grant delay %0d burst", d), last_burst, 1);
        end

        // R7 / R8: withhold grant for k intervals
        for (int k = 1; k <= 6; k++) begin
            gnt_en = 0;
            wait_rise();
            repeat (k * IVAL - 30) @(posedge clk);
            gnt_en = 1;
            wait_fall();
            exp = (k < MAXD) ? k : MAXD;
            chk(last_burst == exp, $sformatf("R8 debt burst after %0d intervals", k),
                last_burst, exp);
        end

        chk(e1 == 0, "R1 nothing during pause", e1, 0);
        chk(e2 == 0, "R2 strobes only with grant", e2, 0);
        chk(e3 == 0, "R3 CBR order and WE high", e3, 0);
        chk(e4 == 0, "R4 RAS width and precharge", e4, 0);
        chk(e5 == 0, "R5 ganged strobes", e5, 0);
        chk(e6 == 0, "R6 init_done sticky", e6, 0);
        chk(e9 == 0, "R9 release after precharge", e9, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule